// File: doc/BRIEF.md
# Link BIST Pattern Generator and Checker

This block provides built-in self-test for a byte-oriented serial link. It sits above the line coder. The transmit half produces one decoded symbol per clock: a byte, a control (K) flag and a violation flag. The receive half takes the symbols decoded at the far end of the link and judges them. Both halves step the same 9-bit maximal-length LFSR, so a full loop is 511 symbols long. Each LFSR state maps to one symbol, and the loop covers every data byte, the K28.x control codes, the remaining control codes and one explicit violation symbol.

The generator is re-seeded by a violation request. It marks the last symbol of every loop with a low pulse on its strobe. When neither load enable is active, it sends an alternating D10.2/D21.5 idle pattern. The checker stays quiet until the loop-start symbol D0.0 arrives. It then compares every byte it receives with its own expected symbol and raises a ready pulse on the last symbol of each loop. Leaving and re-entering receive BIST drops its lock.

Top module: `link_bist`

## Requirements
- R1: LFSR step is next = {s[7:0], s[8]^s[4]} (x^9+x^5+1), and the seed is 9'h100. State s maps to byte s[7:0]. K is set when s[8]=1 and either s[4:0]=28, or s[7:5]=7 with s[4:0] in {23,27,29,30}. The violation flag is set only for s=9'h1FF. With BIST on, no violation request and a load enable active, each clock emits the symbol of the current state and then steps the state, so a loop is 511 symbols and starts with D0.0 (byte 0, K=0, violation=0).
- R2: With BIST on and no load enable active, the transmitter emits K=0 bytes alternating 8'h4A (D10.2) and 8'hB5 (D21.5). The first such byte after reset is 8'h4A, and the alternation resumes where it left off.
- R3: The next-enable input (active low) sampled low at one clock makes the transmitter emit a sequence symbol at the following clock. The immediate load enable (active low) acts at the same clock.
- R4: A violation request with BIST on emits byte 0, K=0, violation=1 and re-seeds the generator, so the next sequence symbol is D0.0.
- R5: The transmit strobe is high except on the last symbol of a loop (state 9'h080, byte 8'h80, K=0), where it is low for one clock.
- R6: After reset or after receive BIST is enabled, the mismatch and ready outputs stay low until a D0.0 symbol is received.
- R7: Once locked, each valid received symbol that differs in byte, K or violation flag from the expected symbol drives mismatch high for that byte. A matching symbol drives it low.
- R8: The violation symbol and the control codes that belong to the expected loop do not raise mismatch.
- R9: Once locked, ready is high for exactly the byte time of the last symbol of each loop (expected state 9'h080) and low otherwise.
- R10: Dropping receive BIST clears the lock, mismatch and ready at the next clock. Re-entering BIST waits for a new D0.0.
- R11: After reset the transmit outputs are zero, the strobe is high, and mismatch and ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bist_en | input | 1 | Transmit BIST enable |
| tx_load_n | input | 1 | Immediate load enable, active low |
| tx_next_n | input | 1 | Next-clock load enable, active low |
| tx_viol_req | input | 1 | Violation request / generator re-seed |
| tx_byte | output | 8 | Transmitted symbol byte |
| tx_k | output | 1 | Transmitted symbol is a control code |
| tx_viol | output | 1 | Transmitted symbol is a violation |
| tx_strobe_n | output | 1 | Low on the last symbol of a loop |
| rx_bist_en | input | 1 | Receive BIST enable |
| rx_valid | input | 1 | A decoded symbol is present |
| rx_byte | input | 8 | Decoded byte |
| rx_k | input | 1 | Decoded control flag |
| rx_viol | input | 1 | Decoded violation flag |
| rx_mismatch | output | 1 | Last received symbol differed from expected |
| rx_ready | output | 1 | Last received symbol closed a loop |

## Verification
Mismatch and the loop-end ready pulse can fall on the same byte. To provoke this, the bench corrupts one bit of the final symbol of a loop (byte 8'h80) on the loopback path, and both outputs must then be high together. On the following byte mismatch must fall while the checker resumes at D0.0. A scoreboard model fed from the requirements supplies every expected value. The same loop also runs the expected violation symbol through, to show that a coincidence with an expected violation stays silent.

// File: rtl/link_bist.sv
module link_bist (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_bist_en,
  input  logic       tx_load_n,
  input  logic       tx_next_n,
  input  logic       tx_viol_req,
  output logic [7:0] tx_byte,
  output logic       tx_k,
  output logic       tx_viol,
  output logic       tx_strobe_n,
  input  logic       rx_bist_en,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_k,
  input  logic       rx_viol,
  output logic       rx_mismatch,
  output logic       rx_ready
);
  localparam logic [8:0] SEED      = 9'h100;
  localparam logic [9:0] SYM_START = 10'h000;
  localparam logic [9:0] SYM_VREQ  = 10'h001;
  localparam logic [7:0] ALT_A     = 8'h4A;
  localparam logic [7:0] ALT_B     = 8'hB5;

  function automatic logic [8:0] lfsr_step(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  function automatic logic [9:0] state_sym(input logic [8:0] s);
    logic k;
    k = s[8] & ((s[4:0] == 5'd28) |
                ((s[7:5] == 3'd7) & ((s[4:0] == 5'd23) | (s[4:0] == 5'd27) |
                                     (s[4:0] == 5'd29) | (s[4:0] == 5'd30))));
    return {s[7:0], k, s[8] & (s[7:0] == 8'hFF)};
  endfunction

  logic [8:0] gen_st, exp_st;
  logic [9:0] tx_sym;
  logic       alt_ph, next_q, locked;

  wire        run     = ~tx_load_n | next_q;
  wire  [8:0] gen_nx  = lfsr_step(gen_st);
  wire  [8:0] exp_nx  = lfsr_step(exp_st);
  wire  [9:0] rx_sym  = {rx_byte, rx_k, rx_viol};

  assign {tx_byte, tx_k, tx_viol} = tx_sym;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_st      <= SEED;
      tx_sym      <= '0;
      tx_strobe_n <= 1'b1;
      alt_ph      <= 1'b0;
      next_q      <= 1'b0;
    end else begin
      next_q <= ~tx_next_n;
      if (!tx_bist_en) begin
        gen_st      <= SEED;
        tx_sym      <= '0;
        tx_strobe_n <= 1'b1;
      end else if (tx_viol_req) begin
        gen_st      <= SEED;
        tx_sym      <= SYM_VREQ;
        tx_strobe_n <= 1'b1;
      end else if (run) begin
        tx_sym      <= state_sym(gen_st);
        gen_st      <= gen_nx;
        tx_strobe_n <= (gen_nx != SEED);
      end else begin
        tx_sym      <= {alt_ph ? ALT_B : ALT_A, 2'b00};
        alt_ph      <= ~alt_ph;
        tx_strobe_n <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked      <= 1'b0;
      exp_st      <= SEED;
      rx_mismatch <= 1'b0;
      rx_ready    <= 1'b0;
    end else if (!rx_bist_en) begin
      locked      <= 1'b0;
      rx_mismatch <= 1'b0;
      rx_ready    <= 1'b0;
    end else if (rx_valid) begin
      if (!locked) begin
        rx_mismatch <= 1'b0;
        rx_ready    <= 1'b0;
        if (rx_sym == SYM_START) begin
          locked <= 1'b1;
          exp_st <= lfsr_step(SEED);
        end
      end else begin
        rx_mismatch <= (rx_sym != state_sym(exp_st));
        rx_ready    <= (exp_nx == SEED);
        exp_st      <= exp_nx;
      end
    end
  end
endmodule

module link_bist_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_bist_en,
  input logic       tx_load_n,
  input logic       tx_next_n,
  input logic       tx_viol_req,
  input logic [7:0] tx_byte,
  input logic       tx_k,
  input logic       tx_viol,
  input logic       tx_strobe_n,
  input logic       rx_bist_en,
  input logic       rx_valid,
  input logic       rx_mismatch,
  input logic       rx_ready
);
  logic prev_next_n;
  always_ff @(posedge clk)
    if (!rst_n) prev_next_n <= 1'b1;
    else        prev_next_n <= tx_next_n;

  // R2
  alt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bist_en && tx_load_n && prev_next_n && !tx_viol_req)
      |=> (!tx_k && !tx_viol && (tx_byte == 8'h4A || tx_byte == 8'hB5)));

  // R4
  viol_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bist_en && tx_viol_req) |=> (tx_viol && !tx_k && tx_byte == 8'h00));

  // R5
  loop_end_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_strobe_n |-> (tx_byte == 8'h80 && !tx_k && !tx_viol));

  // R9
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && rx_valid && rx_bist_en) |=> !rx_ready);

  // R10
  rx_exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bist_en |=> (!rx_mismatch && !rx_ready));
endmodule

bind link_bist link_bist_chk u_link_bist_chk (
  .clk(clk), .rst_n(rst_n), .tx_bist_en(tx_bist_en), .tx_load_n(tx_load_n),
  .tx_next_n(tx_next_n), .tx_viol_req(tx_viol_req), .tx_byte(tx_byte),
  .tx_k(tx_k), .tx_viol(tx_viol), .tx_strobe_n(tx_strobe_n),
  .rx_bist_en(rx_bist_en), .rx_valid(rx_valid), .rx_mismatch(rx_mismatch),
  .rx_ready(rx_ready)
);

// File: tb/test_link_bist.sv
`timescale 1ns/1ps
module test_link_bist;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_bist_en = 0, tx_load_n = 1, tx_next_n = 1, tx_viol_req = 0;
  logic rx_bist_en = 0, rx_valid = 0;
  logic [7:0] flip = 8'h00;
  logic [7:0] tx_byte;
  logic tx_k, tx_viol, tx_strobe_n, rx_mismatch, rx_ready;
  logic [7:0] rx_byte;

  always #2.5 clk = ~clk;
  assign rx_byte = tx_byte ^ flip;

  link_bist i_link_bist (
    .clk(clk), .rst_n(rst_n), .tx_bist_en(tx_bist_en), .tx_load_n(tx_load_n),
    .tx_next_n(tx_next_n), .tx_viol_req(tx_viol_req), .tx_byte(tx_byte),
    .tx_k(tx_k), .tx_viol(tx_viol), .tx_strobe_n(tx_strobe_n),
    .rx_bist_en(rx_bist_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_k(tx_k), .rx_viol(tx_viol), .rx_mismatch(rx_mismatch), .rx_ready(rx_ready)
  );

  typedef struct {
    logic [12:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // requirement model state
  logic [8:0] m_st = 9'h100, m_exp = 9'h100;
  logic [7:0] m_b = 0;
  logic m_k = 0, m_v = 0, m_s = 1, m_alt = 0, m_nq = 0, m_lock = 0, m_mis = 0, m_rdy = 0;

  function automatic logic [8:0] m_step(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction
  function automatic logic [9:0] m_sym(input logic [8:0] s);
    logic k, v;
    k = s[8] && (s[4:0] == 28 || (s[7:5] == 7 &&
        (s[4:0] == 23 || s[4:0] == 27 || s[4:0] == 29 || s[4:0] == 30)));
    v = (s == 9'h1FF);
    return {s[7:0], k, v};
  endfunction

  task automatic cyc(input logic ld_n, nx_n, vr, ten, ren, rval,
                     input logic [7:0] fl, input string tag);
    logic [9:0] rin, e;
    logic run;
    string t;
    exp_t it;
    tx_load_n = ld_n; tx_next_n = nx_n; tx_viol_req = vr;
    tx_bist_en = ten; rx_bist_en = ren; rx_valid = rval; flip = fl;
    t = tag;
    rin = {m_b ^ fl, m_k, m_v};
    if (!ren) begin m_lock = 0; m_mis = 0; m_rdy = 0; end
    else if (rval) begin
      if (!m_lock) begin
        m_mis = 0; m_rdy = 0;
        if (rin == 10'h000) begin m_lock = 1; m_exp = m_step(9'h100); end
      end else begin
        e = m_sym(m_exp);
        m_mis = (rin != e);
        m_rdy = (m_exp == 9'h080);
        if (e[0]) t = "R8";
        if (m_rdy) t = "R9";
        if (fl != 0) t = m_rdy ? "R7+R9" : "R7";
        m_exp = m_step(m_exp);
      end
    end
    run = !ld_n || m_nq;
    m_nq = !nx_n;
    if (!ten) begin m_st = 9'h100; {m_b, m_k, m_v} = 10'h000; m_s = 1; end
    else if (vr) begin m_st = 9'h100; {m_b, m_k, m_v} = 10'h001; m_s = 1; end
    else if (run) begin
      {m_b, m_k, m_v} = m_sym(m_st);
      m_s = (m_st != 9'h080);
      if (!m_s) t = "R5";
      m_st = m_step(m_st);
    end else begin
      {m_b, m_k, m_v} = {m_alt ? 8'hB5 : 8'h4A, 2'b00};
      m_alt = !m_alt; m_s = 1;
    end
    it.val = {m_b, m_k, m_v, m_s, m_mis, m_rdy};
    it.tag = t;
    sb.push_back(it);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      logic [12:0] act;
      #1;
      it = sb.pop_front();
      act = {tx_byte, tx_k, tx_viol, tx_strobe_n, rx_mismatch, rx_ready};
      checks++;
      if (act !== it.val) begin
        fails++;
        $display("FAIL %s: got %h exp %h", it.tag, act, it.val);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen_d00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    cyc(1, 1, 0, 0, 0, 0, 0, "R11");
    // R2 alternating idle pattern; R6 checker idle on non-start bytes
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 1, 1, 1, 0, "R2");
    // R4 violation request re-seeds
    cyc(1, 1, 1, 1, 1, 1, 0, "R4");
    // R1 run; corrupt byte 150 (R7) and a loop-end byte (R7+R9)
    for (int i = 0; i < 1100; i++) begin
      logic [7:0] f;
      f = 8'h00;
      if (i == 150) f = 8'h04;
      if (i > 600 && m_b == 8'h80 && !m_k && !m_v) f = 8'h10;
      cyc(0, 1, 0, 1, 1, 1, f, i < 3 ? "R6" : "R1");
    end
    // R10 leave receive BIST
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, 0, 1, 0, "R10");
    // R3 next-enable with receive off
    cyc(1, 0, 0, 1, 0, 1, 0, "R3");
    cyc(1, 1, 0, 1, 0, 1, 0, "R3");
    cyc(1, 1, 0, 1, 0, 1, 0, "R3");
    cyc(1, 1, 0, 1, 0, 1, 0, "R2");
    // R10 re-enter: idle until next D0.0, then clean compare
    seen_d00 = 0;
    for (int i = 0; i < 700; i++) cyc(0, 1, 0, 1, 1, 1, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule